// File: doc/BRIEF.md
# Multi-Antenna Spectral Cross-Correlator

This block is the multiply-accumulate stage of a frequency-domain (FX) correlator. Samples arrive after channelization. On every active cycle the block takes one 2-bit complex sample from each antenna, all for the same frequency channel. For every antenna pair it forms the product of the first antenna's sample and the conjugate of the second's. That product is added into a signed real accumulator and a signed imaginary accumulator kept for the pair and the channel. No lag computation is done in hardware.

An integration length, counted in complete channel sweeps (frames), sets when a result is ready. When the last sample of the final frame arrives, every accumulator is copied into a shadow bank and restarted from zero in the same cycle. Sampling therefore continues with no gap. The shadow bank drains through a valid/ready port, one pair and one channel per beat, while the next integration builds up. With 1.5625 MHz channel samples, an integration of 10 ms to 50 s needs an integration length of 15,625 to 78,125,000 frames. The largest possible sum is 78,125,000 × 18, which fits comfortably in the default 40-bit accumulators.

Top module: `xcorr_top`

## Requirements
- R1: Antenna k's sample sits in `sampleData[4k+3:4k]`: the real code is in bits [1:0] of that nibble and the imaginary code is in bits [3:2]. Each 2-bit code maps to a level: 00 → -3, 01 → -1, 10 → +1, 11 → +3.
- R2: For each pair (a, b) with a < b, a valid sample adds ar·br + ai·bi to the real sum and ai·br − ar·bi to the imaginary sum of the channel given by `sampleChan`. Sums of other channels do not change.
- R3: A cycle with `sampleValid` low changes no sum, whatever is on `sampleChan` and `sampleData`.
- R4: A frame ends on a valid sample with `sampleChan` = NUM_CHAN−1. The sample that completes frame number `intLen` is included in the dumped sums. All sums restart from zero on that cycle. Samples that arrive while readout is in progress count toward the next integration.
- R5: After a dump, readout delivers NUM_CHAN × NUM_ANT(NUM_ANT−1)/2 entries. Channels run 0 upward. Within each channel, pairs run (0,1), (0,2) … (0,N−1), (1,2) … (N−2,N−1). After the last accepted entry `outValid` goes low.
- R6: While `outValid` is high and `outReady` is low, every readout output holds its value.
- R7: A channel in which every antenna carries the same sample yields an imaginary sum of zero and a positive real sum.
- R8: During and after reset `outValid` is low, and the first integration starts from zero sums.
- R9: An `intLen` of 0 behaves as an integration of one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| intLen | input | CNTW | Integration length in frames |
| sampleValid | input | 1 | Sample strobe |
| sampleChan | input | log2(NUM_CHAN) | Channel index of the current sample |
| sampleData | input | 4·NUM_ANT | Packed 2-bit complex samples, one nibble per antenna |
| outReady | input | 1 | Readout consumer ready |
| outValid | output | 1 | Readout entry valid |
| outChan | output | log2(NUM_CHAN) | Channel of the current entry |
| outAntA | output | log2(NUM_ANT) | First antenna of the pair |
| outAntB | output | log2(NUM_ANT) | Second (conjugated) antenna of the pair |
| outRe | output | ACCW | Signed real sum |
| outIm | output | ACCW | Signed imaginary sum |

## Verification
The bench builds the block with three antennas and four channels. This gives three pairs, so the pair counter wraps at a count that is not a power of two. The per-channel sweep is short enough that integrations of zero, one, two, three and four frames all finish within a few dozen cycles. These settings also let one integration of four back-to-back frames run while the previous readout drains, which exposes any sample lost at the dump boundary. One channel carries identical samples on all three antennas, so every dump includes a result that must be purely real and positive.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

  typedef struct packed {
    logic accEn;   // add products of the current sample
    logic dump;    // copy sums to shadow bank and restart
  } ctlStrobes_t;

  // 2-bit code to odd level: 00->-3, 01->-1, 10->+1, 11->+3
  function automatic logic signed [2:0] codeLevel(input logic [1:0] code);
    return {~code[1], code[0], 1'b1};
  endfunction

  // first antenna of pair number idx among n antennas
  function automatic int pairFirst(input int idx, input int n);
    int k;
    int r;
    k = 0;
    r = 0;
    for (int a = 0; a < n; a++)
      for (int b = a + 1; b < n; b++) begin
        if (k == idx) r = a;
        k++;
      end
    return r;
  endfunction

  // second antenna of pair number idx among n antennas
  function automatic int pairSecond(input int idx, input int n);
    int k;
    int r;
    k = 0;
    r = 1;
    for (int a = 0; a < n; a++)
      for (int b = a + 1; b < n; b++) begin
        if (k == idx) r = b;
        k++;
      end
    return r;
  endfunction

endpackage

// File: rtl/xcorr_ctrl.sv
module xcorr_ctrl
  import xcorr_pkg::*;
#(
  parameter int NUM_ANT  = 4,
  parameter int NUM_CHAN = 8,
  parameter int CNTW     = 32,
  localparam int NBL  = NUM_ANT * (NUM_ANT - 1) / 2,
  localparam int CHW  = $clog2(NUM_CHAN),
  localparam int BLW  = (NBL > 1) ? $clog2(NBL) : 1,
  localparam int ANTW = $clog2(NUM_ANT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CNTW-1:0] intLen,
  input  logic            sampleValid,
  input  logic [CHW-1:0]  sampleChan,
  input  logic            outReady,
  output ctlStrobes_t     stb,
  output logic            rdActive,
  output logic [CHW-1:0]  rdChan,
  output logic [BLW-1:0]  rdBl,
  output logic [ANTW-1:0] rdAntA,
  output logic [ANTW-1:0] rdAntB
);

  logic [CNTW-1:0] frameCnt;
  logic [CNTW-1:0] effLen;
  logic            frameEnd;
  logic            intEnd;

  assign effLen   = (intLen == '0) ? CNTW'(1) : intLen;
  assign frameEnd = sampleValid && (sampleChan == CHW'(NUM_CHAN - 1));
  assign intEnd   = frameEnd && (frameCnt >= effLen - CNTW'(1));

  always_comb begin
    stb.accEn = sampleValid;
    stb.dump  = intEnd;
  end

  always_ff @(posedge clk) begin
    if (rst)           frameCnt <= '0;
    else if (intEnd)   frameCnt <= '0;
    else if (frameEnd) frameCnt <= frameCnt + CNTW'(1);
  end

  // readout walker: channel-major, pair-minor
  always_ff @(posedge clk) begin
    if (rst) begin
      rdActive <= 1'b0;
      rdChan   <= '0;
      rdBl     <= '0;
      rdAntA   <= '0;
      rdAntB   <= ANTW'(1);
    end else if (intEnd) begin
      rdActive <= 1'b1;
      rdChan   <= '0;
      rdBl     <= '0;
      rdAntA   <= '0;
      rdAntB   <= ANTW'(1);
    end else if (rdActive && outReady) begin
      if (rdBl == BLW'(NBL - 1)) begin
        rdBl   <= '0;
        rdAntA <= '0;
        rdAntB <= ANTW'(1);
        if (rdChan == CHW'(NUM_CHAN - 1)) rdActive <= 1'b0;
        else                              rdChan   <= rdChan + CHW'(1);
      end else begin
        rdBl <= rdBl + BLW'(1);
        if (rdAntB == ANTW'(NUM_ANT - 1)) begin
          rdAntA <= rdAntA + ANTW'(1);
          rdAntB <= rdAntA + ANTW'(2);
        end else begin
          rdAntB <= rdAntB + ANTW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/xcorr_dpath.sv
module xcorr_dpath
  import xcorr_pkg::*;
#(
  parameter int NUM_ANT  = 4,
  parameter int NUM_CHAN = 8,
  parameter int ACCW     = 40,
  localparam int NBL  = NUM_ANT * (NUM_ANT - 1) / 2,
  localparam int CHW  = $clog2(NUM_CHAN),
  localparam int BLW  = (NBL > 1) ? $clog2(NBL) : 1,
  localparam int PRW  = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctlStrobes_t            stb,
  input  logic [CHW-1:0]         sampleChan,
  input  logic [4*NUM_ANT-1:0]   sampleData,
  input  logic [CHW-1:0]         rdChan,
  input  logic [BLW-1:0]         rdBl,
  output logic signed [ACCW-1:0] rdRe,
  output logic signed [ACCW-1:0] rdIm
);

  logic signed [PRW-1:0]  prodRe [NBL];
  logic signed [PRW-1:0]  prodIm [NBL];
  logic signed [ACCW-1:0] accRe  [NBL][NUM_CHAN];
  logic signed [ACCW-1:0] accIm  [NBL][NUM_CHAN];
  logic signed [ACCW-1:0] sumRe  [NBL][NUM_CHAN];
  logic signed [ACCW-1:0] sumIm  [NBL][NUM_CHAN];
  logic signed [ACCW-1:0] shRe   [NBL][NUM_CHAN];
  logic signed [ACCW-1:0] shIm   [NBL][NUM_CHAN];

  // one conjugate multiplier per antenna pair
  for (genvar bl = 0; bl < NBL; bl++) begin : g_pair
    localparam int ANT_A = pairFirst(bl, NUM_ANT);
    localparam int ANT_B = pairSecond(bl, NUM_ANT);
    logic signed [PRW-1:0] aRe, aIm, bRe, bIm;
    assign aRe = PRW'(codeLevel(sampleData[4*ANT_A +: 2]));
    assign aIm = PRW'(codeLevel(sampleData[4*ANT_A+2 +: 2]));
    assign bRe = PRW'(codeLevel(sampleData[4*ANT_B +: 2]));
    assign bIm = PRW'(codeLevel(sampleData[4*ANT_B+2 +: 2]));
    assign prodRe[bl] = aRe * bRe + aIm * bIm;
    assign prodIm[bl] = aIm * bRe - aRe * bIm;
  end

  always_comb begin
    for (int bl = 0; bl < NBL; bl++)
      for (int ch = 0; ch < NUM_CHAN; ch++) begin
        sumRe[bl][ch] = accRe[bl][ch];
        sumIm[bl][ch] = accIm[bl][ch];
        if (stb.accEn && (sampleChan == CHW'(ch))) begin
          sumRe[bl][ch] = accRe[bl][ch] + ACCW'(prodRe[bl]);
          sumIm[bl][ch] = accIm[bl][ch] + ACCW'(prodIm[bl]);
        end
      end
  end

  always_ff @(posedge clk) begin
    for (int bl = 0; bl < NBL; bl++)
      for (int ch = 0; ch < NUM_CHAN; ch++) begin
        if (rst) begin
          accRe[bl][ch] <= '0;
          accIm[bl][ch] <= '0;
          shRe[bl][ch]  <= '0;
          shIm[bl][ch]  <= '0;
        end else if (stb.dump) begin
          shRe[bl][ch]  <= sumRe[bl][ch];
          shIm[bl][ch]  <= sumIm[bl][ch];
          accRe[bl][ch] <= '0;
          accIm[bl][ch] <= '0;
        end else begin
          accRe[bl][ch] <= sumRe[bl][ch];
          accIm[bl][ch] <= sumIm[bl][ch];
        end
      end
  end

  assign rdRe = shRe[rdBl][rdChan];
  assign rdIm = shIm[rdBl][rdChan];

endmodule

// File: rtl/xcorr_top.sv
module xcorr_top
  import xcorr_pkg::*;
#(
  parameter int NUM_ANT  = 4,
  parameter int NUM_CHAN = 8,
  parameter int ACCW     = 40,
  parameter int CNTW     = 32,
  localparam int NBL  = NUM_ANT * (NUM_ANT - 1) / 2,
  localparam int CHW  = $clog2(NUM_CHAN),
  localparam int BLW  = (NBL > 1) ? $clog2(NBL) : 1,
  localparam int ANTW = $clog2(NUM_ANT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNTW-1:0]        intLen,
  input  logic                   sampleValid,
  input  logic [CHW-1:0]         sampleChan,
  input  logic [4*NUM_ANT-1:0]   sampleData,
  input  logic                   outReady,
  output logic                   outValid,
  output logic [CHW-1:0]         outChan,
  output logic [ANTW-1:0]        outAntA,
  output logic [ANTW-1:0]        outAntB,
  output logic signed [ACCW-1:0] outRe,
  output logic signed [ACCW-1:0] outIm
);

  ctlStrobes_t     stb;
  logic [BLW-1:0]  rdBl;
  logic            dumpNow;

  assign dumpNow = stb.dump;

  xcorr_ctrl #(
    .NUM_ANT(NUM_ANT), .NUM_CHAN(NUM_CHAN), .CNTW(CNTW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .intLen(intLen),
    .sampleValid(sampleValid), .sampleChan(sampleChan),
    .outReady(outReady), .stb(stb),
    .rdActive(outValid), .rdChan(outChan), .rdBl(rdBl),
    .rdAntA(outAntA), .rdAntB(outAntB)
  );

  xcorr_dpath #(
    .NUM_ANT(NUM_ANT), .NUM_CHAN(NUM_CHAN), .ACCW(ACCW)
  ) u_dpath (
    .clk(clk), .rst(rst), .stb(stb),
    .sampleChan(sampleChan), .sampleData(sampleData),
    .rdChan(outChan), .rdBl(rdBl),
    .rdRe(outRe), .rdIm(outIm)
  );

endmodule

// File: rtl/xcorr_checker.sv
module xcorr_checker #(
  parameter int NUM_ANT  = 4,
  parameter int NUM_CHAN = 8,
  parameter int ACCW     = 40,
  localparam int CHW  = $clog2(NUM_CHAN),
  localparam int ANTW = $clog2(NUM_ANT)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   outValid,
  input logic                   outReady,
  input logic [CHW-1:0]         outChan,
  input logic [ANTW-1:0]        outAntA,
  input logic [ANTW-1:0]        outAntB,
  input logic signed [ACCW-1:0] outRe,
  input logic signed [ACCW-1:0] outIm,
  input logic                   dumpNow
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !outValid); // R8

  AST_DUMP_START: assert property (@(posedge clk) disable iff (rst)
    dumpNow |=> outValid && outChan == '0 && outAntA == '0 && outAntB == ANTW'(1)); // R4

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outAntA < outAntB); // R5

  AST_DRAIN_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $fell(outValid) |-> $past(outReady)); // R5

  AST_LAST_ENTRY: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && !dumpNow && outChan == CHW'(NUM_CHAN - 1)
      && outAntA == ANTW'(NUM_ANT - 2) && outAntB == ANTW'(NUM_ANT - 1)
    |=> !outValid); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady && !dumpNow |=> outValid && $stable(outRe) && $stable(outIm)
      && $stable(outChan) && $stable(outAntA) && $stable(outAntB)); // R6

endmodule

bind xcorr_top xcorr_checker #(
  .NUM_ANT(NUM_ANT), .NUM_CHAN(NUM_CHAN), .ACCW(ACCW)
) u_chk (.*);

// File: tb/tb_xcorr_top.sv
module tb_xcorr_top;

  localparam int NA    = 3;
  localparam int NC    = 4;
  localparam int AW    = 40;
  localparam int CW    = 32;
  localparam int NP    = NA * (NA - 1) / 2;
  localparam int TOTAL = NP * NC;
  localparam int SAME_CH = 2;

  // stimulus: {chan[1:0], data[11:0]}, two frames; channel 2 identical on all antennas
  localparam logic [13:0] STIM [8] = '{
    {2'd0, 12'h1B4}, {2'd1, 12'h9C3}, {2'd2, 12'h666}, {2'd3, 12'hF02},
    {2'd0, 12'h3A5}, {2'd1, 12'h7E1}, {2'd2, 12'hDDD}, {2'd3, 12'h48C}
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [CW-1:0]        intLen = '0;
  logic                 sampleValid = 1'b0;
  logic [1:0]           sampleChan = '0;
  logic [4*NA-1:0]      sampleData = '0;
  logic                 outReady = 1'b0;
  logic                 outValid;
  logic [1:0]           outChan;
  logic [1:0]           outAntA;
  logic [1:0]           outAntB;
  logic signed [AW-1:0] outRe;
  logic signed [AW-1:0] outIm;

  always #4 clk = ~clk;

  xcorr_top #(.NUM_ANT(NA), .NUM_CHAN(NC), .ACCW(AW), .CNTW(CW)) dut (.*);

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  longint refRe [NC][NP];
  longint refIm [NC][NP];
  longint snapRe [NC][NP];
  longint snapIm [NC][NP];
  int pa [NP];
  int pb [NP];
  int frames = 0;
  int rdK = TOTAL;
  bit drainPending = 1'b0;
  bit holdPending = 1'b0;
  logic [AW-1:0] hRe, hIm;
  logic [1:0] hCh, hA, hB;

  // R1: code c maps to level 2c-3; real in nibble bits [1:0], imaginary in [3:2]
  function automatic int lvl(input logic [1:0] c);
    return 2 * int'(c) - 3;
  endfunction

  function automatic int effLen();
    return (intLen == 0) ? 1 : int'(intLen);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic modelSample(input logic [1:0] ch, input logic [4*NA-1:0] d);
    for (int p = 0; p < NP; p++) begin
      int ar, ai, br, bi;
      ar = lvl(d[4*pa[p] +: 2]);
      ai = lvl(d[4*pa[p]+2 +: 2]);
      br = lvl(d[4*pb[p] +: 2]);
      bi = lvl(d[4*pb[p]+2 +: 2]);
      refRe[ch][p] += ar * br + ai * bi;
      refIm[ch][p] += ai * br - ar * bi;
    end
    if (ch == 2'(NC - 1)) begin
      frames++;
      if (frames >= effLen()) begin
        for (int c = 0; c < NC; c++)
          for (int p = 0; p < NP; p++) begin
            snapRe[c][p] = refRe[c][p];
            snapIm[c][p] = refIm[c][p];
            refRe[c][p] = 0;
            refIm[c][p] = 0;
          end
        frames = 0;
        rdK = 0;
        holdPending = 1'b0;
        drainPending = 1'b0;
      end
    end
  endtask

  task automatic checkTransfer();
    int c, p;
    if (rdK >= TOTAL) begin
      check(1'b0, "R5", "unexpected entry", longint'(rdK), TOTAL);
      return;
    end
    c = rdK / NP;
    p = rdK % NP;
    check(outChan == 2'(c), "R5", "channel order", outChan, c);
    check(outAntA == 2'(pa[p]) && outAntB == 2'(pb[p]), "R5", "pair order",
          outAntA * 10 + outAntB, pa[p] * 10 + pb[p]);
    check(longint'(outRe) == snapRe[c][p], "R2", "real sum", outRe, snapRe[c][p]);
    check(longint'(outIm) == snapIm[c][p], "R2", "imag sum", outIm, snapIm[c][p]);
    if (c == SAME_CH)
      check(outIm == 0 && outRe > 0, "R7", "identical inputs real-only", outIm, 0);
    rdK++;
    if (rdK == TOTAL) drainPending = 1'b1;
  endtask

  // one cycle: drive at negedge, check outputs registered at the previous posedge
  task automatic step(input logic v, input logic [1:0] ch, input logic [4*NA-1:0] d,
                      input logic rdy);
    @(negedge clk);
    if (drainPending) begin
      check(outValid == 1'b0, "R5", "valid after last entry", outValid, 0);
      drainPending = 1'b0;
    end
    if (holdPending) begin
      check(outValid && outRe == hRe && outIm == hIm && outChan == hCh
            && outAntA == hA && outAntB == hB, "R6", "stall hold", outRe, hRe);
      holdPending = 1'b0;
    end
    sampleValid = v;
    sampleChan  = ch;
    sampleData  = d;
    outReady    = rdy;
    if (outValid && rdy) checkTransfer();
    if (outValid && !rdy) begin
      holdPending = 1'b1;
      hRe = outRe; hIm = outIm; hCh = outChan; hA = outAntA; hB = outAntB;
    end
    if (v) modelSample(ch, d);   // R3: invalid cycles leave the model unchanged
  endtask

  function automatic logic [4*NA-1:0] rndData(input logic [1:0] ch);
    logic [4*NA-1:0] d;
    logic [3:0] n;
    d = 12'($urandom);
    if (ch == 2'(SAME_CH)) begin
      n = 4'($urandom);
      d = {n, n, n};
    end
    return d;
  endfunction

  task automatic drain(input bit randomReady);
    while (rdK < TOTAL)
      step(1'b0, 2'($urandom), 12'($urandom), randomReady ? 1'($urandom) : 1'b1);
    step(1'b0, 2'd0, 12'd0, 1'b1);
  endtask

  task automatic randomIntegration(input int nFrames, input bit gaps);
    for (int f = 0; f < nFrames; f++)
      for (int c = 0; c < NC; c++) begin
        if (gaps && ($urandom % 3 == 0))
          step(1'b0, 2'($urandom), 12'($urandom), 1'($urandom));   // R3
        step(1'b1, 2'(c), rndData(2'(c)), gaps ? 1'($urandom) : 1'b1);
      end
  endtask

  initial begin
    begin
      int k = 0;
      for (int a = 0; a < NA; a++)
        for (int b = a + 1; b < NA; b++) begin
          pa[k] = a; pb[k] = b; k++;
        end
    end
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < NP; p++) begin
        refRe[c][p] = 0; refIm[c][p] = 0;
      end

    // R8: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R8", "valid in reset", outValid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R8", "valid after reset", outValid, 0);

    // table walk: two-frame integration (R1, R2, R4, R7)
    intLen = 2;
    for (int i = 0; i < 8; i++)
      step(1'b1, STIM[i][13:12], STIM[i][11:0], 1'b1);
    drain(1'b0);

    // three frames with invalid gaps and random backpressure (R3, R6)
    intLen = 3;
    randomIntegration(3, 1'b1);
    drain(1'b1);

    // back-to-back integrations: second one runs during readout (R4)
    intLen = 4;
    randomIntegration(4, 1'b0);
    randomIntegration(4, 1'b0);
    drain(1'b0);

    // zero length acts as one frame (R9)
    intLen = 0;
    randomIntegration(1, 1'b0);
    check(rdK == 0, "R9", "dump after one frame", rdK, 0);
    drain(1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule